// File: doc/BRIEF.md
# Configuration Unlock Gate

This block guards the configuration space of a multi-function I/O controller. It snoops host I/O write cycles and stays locked until it sees a key byte written a set number of times to a key port. While it is unlocked, an index port picks one of a handful of internal configuration registers and a data port reads or writes the register picked. A single exit byte written to the key port locks the gate again.

Two unlock schemes exist. The primary scheme writes 0x55 twice to port 0x3F0 and uses 0x3F0/0x3F1 as the index/data pair. With `strap_alt` high, the two `strap_sel` bits select one of four alternative sequences. Each has its own key byte, key port and repeat count, and the key port fixes the index/data pair. The configuration registers hold a logical-device select, a read-only device ID, a chip ID and the 16-bit I/O base of the parallel-port function. The base is visible both as a high/low byte pair and as a base/4 byte, and is driven out on `par_base`.

Top module: `cfg_unlock_gate`

## Requirements
- R1: After reset the gate is locked (`cfg_open`=0), `par_base` is 0x0378, the index is 0x00, the logical-device select is 0x00, and every read returns 0xFF.
- R2: In the primary scheme (`strap_alt`=0), two writes of 0x55 to port 0x3F0 open the gate in the clock after the second write. One such write leaves it locked.
- R3: While locked, a write to the key port of any byte other than the key restarts the key count, so the key must again be written its full number of times.
- R4: While open, writing 0xAA to the key port locks the gate in the next clock. That write does not change the index.
- R5: While locked, reads of the index and data ports return 0xFF and writes to them change no configuration register (`par_base` holds).
- R6: While open, a read of the data port returns the register chosen by the index. Index 0x20 is the device ID and always reads 0x02, and writes to it are ignored. A read of the index port returns the current index.
- R7: Index 0x07 is the logical-device select (read/write). Indices 0x60 (high byte) and 0x61 (low byte) access the parallel base only while the select holds 0x03. Otherwise they read 0x00 and ignore writes.
- R8: With `strap_alt`=1 the key sequence depends on `strap_sel`: 0 → 0x89 once to 0x250, 1 → 0x86 twice to 0x3F0, 2 → 0x87 twice to 0x3F0, 3 → 0x88 once to 0x250.
- R9: When the key port is 0x250, the index/data ports are 0x251/0x252. Otherwise they are 0x3F0/0x3F1. Accesses to the other pair read 0xFF and have no effect.
- R10: Index 0x23 reads bits 9:2 of the parallel base (base divided by 4). A write of value v there sets the base to 4·v with the upper six bits cleared.
- R11: Index 0x09 reads the chip ID (default 0xA) in its low nibble, with the upper nibble zero. Writes to it are ignored.
- R12: Any other index reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_alt | input | 1 | Selects the alternative unlock scheme |
| strap_sel | input | 2 | Chooses the alternative key sequence |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data, 0xFF when nothing responds |
| cfg_open | output | 1 | Gate unlocked |
| par_base | output | 16 | Parallel-port I/O base |

## Verification
The assertions assume the straps are static while reset is released. A change of `strap_sel` would move the key port under a partial key count. They also assume that each host write is a single-cycle strobe, so that one strobe is one key write. The stimulus changes straps only while reset is held, and it drives every access as a one-cycle pulse followed by an idle cycle. The primary scheme and all four alternative sequences are exercised, including interrupted key runs and accesses to the port pair that does not belong to the selected scheme.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;
   localparam int IO_AW = 16;
   localparam int DW    = 8;

   localparam logic [DW-1:0] REG_LDN     = 8'h07;
   localparam logic [DW-1:0] REG_CHIP    = 8'h09;
   localparam logic [DW-1:0] REG_DEVID   = 8'h20;
   localparam logic [DW-1:0] REG_BASE4   = 8'h23;
   localparam logic [DW-1:0] REG_BASE_HI = 8'h60;
   localparam logic [DW-1:0] REG_BASE_LO = 8'h61;

   typedef struct packed {
      logic [IO_AW-1:0] key_port;
      logic [IO_AW-1:0] idx_port;
      logic [IO_AW-1:0] dat_port;
      logic [DW-1:0]    key;
      logic [1:0]       need;
   } scheme_t;

   function automatic scheme_t alt_scheme(input logic [1:0] sel);
      scheme_t s;
      case (sel)
         2'd0:    begin s.key = 8'h89; s.need = 2'd1; s.key_port = 16'h0250; end
         2'd1:    begin s.key = 8'h86; s.need = 2'd2; s.key_port = 16'h03F0; end
         2'd2:    begin s.key = 8'h87; s.need = 2'd2; s.key_port = 16'h03F0; end
         default: begin s.key = 8'h88; s.need = 2'd1; s.key_port = 16'h0250; end
      endcase
      s.idx_port = (s.key_port == 16'h0250) ? 16'h0251 : 16'h03F0;
      s.dat_port = (s.key_port == 16'h0250) ? 16'h0252 : 16'h03F1;
      return s;
   endfunction
endpackage

// File: rtl/cfg_scheme_sel.sv
module cfg_scheme_sel
   import cfg_gate_pkg::*;
#(
   parameter bit               ALT_EN   = 1'b1,
   parameter logic [IO_AW-1:0] PRI_PORT = 16'h03F0,
   parameter logic [DW-1:0]    PRI_KEY  = 8'h55,
   parameter int               PRI_NEED = 2
) (
   input  logic       strap_alt,
   input  logic [1:0] strap_sel,
   output scheme_t    sch
);
   localparam scheme_t PRI_SCH = '{key_port: PRI_PORT,
                                   idx_port: PRI_PORT,
                                   dat_port: PRI_PORT + 16'd1,
                                   key:      PRI_KEY,
                                   need:     2'(PRI_NEED)};
   generate
      if (ALT_EN) begin : g_alt
         always_comb sch = strap_alt ? alt_scheme(strap_sel) : PRI_SCH;
      end else begin : g_pri
         logic unused_straps;
         assign unused_straps = strap_alt ^ (^strap_sel);
         always_comb sch = PRI_SCH;
      end
   endgenerate
endmodule

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
   import cfg_gate_pkg::*;
#(
   parameter logic [DW-1:0] EXIT_CODE = 8'hAA
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             io_wr,
   input  logic [IO_AW-1:0] io_addr,
   input  logic [DW-1:0]    io_wdata,
   input  logic [IO_AW-1:0] key_port,
   input  logic [DW-1:0]    key,
   input  logic [1:0]       need,
   output logic             open,
   output logic             exit_hit
);
   logic [1:0] cnt_q;
   logic       key_wr;
   logic [2:0] cnt_nxt;

   assign key_wr   = io_wr && (io_addr == key_port);
   assign exit_hit = open && key_wr && (io_wdata == EXIT_CODE);
   assign cnt_nxt  = {1'b0, cnt_q} + 3'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open  <= 1'b0;
         cnt_q <= 2'd0;
      end else if (key_wr) begin
         if (open) begin
            if (io_wdata == EXIT_CODE) open <= 1'b0;
         end else if (io_wdata == key) begin
            if (cnt_nxt == {1'b0, need}) begin
               open  <= 1'b1;
               cnt_q <= 2'd0;
            end else begin
               cnt_q <= cnt_nxt[1:0];
            end
         end else begin
            cnt_q <= 2'd0;
         end
      end
   end

   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < need);
   p_wrong_key_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!open && key_wr && io_wdata != key) |=> cnt_q == 2'd0);
   p_exit_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      exit_hit |=> !open);
   p_open_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open) |-> $past(key_wr && io_wdata == key));
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
   import cfg_gate_pkg::*;
#(
   parameter logic [DW-1:0]    DEV_ID   = 8'h02,
   parameter logic [3:0]       CHIP_ID  = 4'hA,
   parameter logic [DW-1:0]    PAR_LDN  = 8'h03,
   parameter logic [IO_AW-1:0] BASE_RST = 16'h0378
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open,
   input  logic             exit_hit,
   input  logic             io_wr,
   input  logic             io_rd,
   input  logic [IO_AW-1:0] io_addr,
   input  logic [DW-1:0]    io_wdata,
   input  logic [IO_AW-1:0] idx_port,
   input  logic [IO_AW-1:0] dat_port,
   output logic [DW-1:0]    io_rdata,
   output logic [IO_AW-1:0] par_base
);
   logic [DW-1:0]    idx_q;
   logic [DW-1:0]    ldn_q;
   logic [IO_AW-1:0] base_q;
   logic             wr_idx, wr_dat, par_sel;
   logic [DW-1:0]    reg_val;

   assign wr_idx  = open && io_wr && (io_addr == idx_port) && !exit_hit;
   assign wr_dat  = open && io_wr && (io_addr == dat_port);
   assign par_sel = (ldn_q == PAR_LDN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         ldn_q  <= '0;
         base_q <= BASE_RST;
      end else begin
         if (wr_idx) idx_q <= io_wdata;
         if (wr_dat) begin
            case (idx_q)
               REG_LDN:     ldn_q <= io_wdata;
               REG_BASE_HI: if (par_sel) base_q[15:8] <= io_wdata;
               REG_BASE_LO: if (par_sel) base_q[7:0]  <= io_wdata;
               REG_BASE4:   base_q <= {6'b0, io_wdata, 2'b00};
               default:     ;
            endcase
         end
      end
   end

   always_comb begin
      case (idx_q)
         REG_LDN:     reg_val = ldn_q;
         REG_CHIP:    reg_val = {4'h0, CHIP_ID};
         REG_DEVID:   reg_val = DEV_ID;
         REG_BASE4:   reg_val = base_q[9:2];
         REG_BASE_HI: reg_val = par_sel ? base_q[15:8] : 8'h00;
         REG_BASE_LO: reg_val = par_sel ? base_q[7:0]  : 8'h00;
         default:     reg_val = 8'h00;
      endcase
   end

   always_comb begin
      io_rdata = 8'hFF;
      if (io_rd && open) begin
         if (io_addr == idx_port)      io_rdata = idx_q;
         else if (io_addr == dat_port) io_rdata = reg_val;
      end
   end

   assign par_base = base_q;

   p_locked_reads_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !open) |-> io_rdata == 8'hFF);
   p_locked_base_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !open |=> $stable(par_base));
   p_devid_const_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (open && io_rd && io_addr == dat_port && idx_q == REG_DEVID) |-> io_rdata == DEV_ID);
   p_base_upper_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dat && idx_q == REG_BASE4) |=> par_base[15:10] == 6'b0);
endmodule

// File: rtl/cfg_unlock_gate.sv
module cfg_unlock_gate
   import cfg_gate_pkg::*;
#(
   parameter bit               ALT_EN    = 1'b1,
   parameter logic [IO_AW-1:0] PRI_PORT  = 16'h03F0,
   parameter logic [DW-1:0]    PRI_KEY   = 8'h55,
   parameter int               PRI_NEED  = 2,
   parameter logic [DW-1:0]    EXIT_CODE = 8'hAA,
   parameter logic [DW-1:0]    DEV_ID    = 8'h02,
   parameter logic [3:0]       CHIP_ID   = 4'hA,
   parameter logic [DW-1:0]    PAR_LDN   = 8'h03,
   parameter logic [IO_AW-1:0] BASE_RST  = 16'h0378
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        strap_alt,
   input  logic [1:0]  strap_sel,
   input  logic [15:0] io_addr,
   input  logic        io_wr,
   input  logic        io_rd,
   input  logic [7:0]  io_wdata,
   output logic [7:0]  io_rdata,
   output logic        cfg_open,
   output logic [15:0] par_base
);
   initial begin
      assert (PRI_NEED >= 1 && PRI_NEED <= 3);
      assert (PRI_KEY != EXIT_CODE);
   end

   scheme_t sch;
   logic    exit_hit;

   cfg_scheme_sel #(
      .ALT_EN(ALT_EN), .PRI_PORT(PRI_PORT), .PRI_KEY(PRI_KEY), .PRI_NEED(PRI_NEED)
   ) sel_i (
      .strap_alt(strap_alt), .strap_sel(strap_sel), .sch(sch)
   );

   cfg_unlock_fsm #(.EXIT_CODE(EXIT_CODE)) fsm_i (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
      .io_wdata(io_wdata), .key_port(sch.key_port), .key(sch.key),
      .need(sch.need), .open(cfg_open), .exit_hit(exit_hit)
   );

   cfg_reg_file #(
      .DEV_ID(DEV_ID), .CHIP_ID(CHIP_ID), .PAR_LDN(PAR_LDN), .BASE_RST(BASE_RST)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .open(cfg_open), .exit_hit(exit_hit),
      .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata),
      .idx_port(sch.idx_port), .dat_port(sch.dat_port),
      .io_rdata(io_rdata), .par_base(par_base)
   );
endmodule

// File: tb/cfg_unlock_gate_tb_top.sv
module cfg_unlock_gate_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_alt = 1'b0;
   logic [1:0]  strap_sel = 2'd0;
   logic [15:0] io_addr = 16'h0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = 8'h0;
   logic [7:0]  io_rdata;
   logic        cfg_open;
   logic [15:0] par_base;

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   always #10 clk = ~clk;

   cfg_unlock_gate dut_i (
      .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .strap_sel(strap_sel),
      .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .cfg_open(cfg_open), .par_base(par_base)
   );

   // behavioural reference
   int m_open, m_cnt, m_idx, m_ldn, m_base;

   function automatic int kport();
      if (!strap_alt) return 'h3F0;
      return (strap_sel == 0 || strap_sel == 3) ? 'h250 : 'h3F0;
   endfunction
   function automatic int kval();
      int keys[4] = '{'h89, 'h86, 'h87, 'h88};
      if (!strap_alt) return 'h55;
      return keys[strap_sel];
   endfunction
   function automatic int kneed();
      if (!strap_alt) return 2;
      return (strap_sel == 1 || strap_sel == 2) ? 2 : 1;
   endfunction
   function automatic int iport();
      return (kport() == 'h250) ? 'h251 : 'h3F0;
   endfunction
   function automatic int dport();
      return (kport() == 'h250) ? 'h252 : 'h3F1;
   endfunction
   function automatic int m_reg(int i);
      case (i)
         'h07: return m_ldn;
         'h09: return 'h0A;
         'h20: return 'h02;
         'h23: return (m_base / 4) % 256;
         'h60: return (m_ldn == 3) ? m_base / 256 : 0;
         'h61: return (m_ldn == 3) ? m_base % 256 : 0;
         default: return 0;
      endcase
   endfunction
   function automatic int m_rdata();
      if (!io_rd || m_open == 0) return 'hFF;
      if (io_addr == iport()) return m_idx;
      if (io_addr == dport()) return m_reg(m_idx);
      return 'hFF;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_open = 0; m_cnt = 0; m_idx = 0; m_ldn = 0; m_base = 'h378;
      end else if (io_wr) begin
         if (m_open != 0) begin
            if (io_addr == kport() && io_wdata == 8'hAA) m_open = 0;
            else begin
               if (io_addr == iport()) m_idx = io_wdata;
               if (io_addr == dport()) begin
                  case (m_idx)
                     'h07: m_ldn = io_wdata;
                     'h60: if (m_ldn == 3) m_base = io_wdata * 256 + m_base % 256;
                     'h61: if (m_ldn == 3) m_base = (m_base / 256) * 256 + io_wdata;
                     'h23: m_base = io_wdata * 4;
                     default: ;
                  endcase
               end
            end
         end else if (io_addr == kport()) begin
            if (io_wdata == kval()) begin
               m_cnt++;
               if (m_cnt == kneed()) begin m_open = 1; m_cnt = 0; end
            end else m_cnt = 0;
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk({cur_req, " rdata"}, int'(io_rdata), m_rdata());
         chk({cur_req, " open"},  int'(cfg_open), m_open);
         chk({cur_req, " base"},  int'(par_base), m_base);
      end
   end

   task automatic idle();
      @(posedge clk); #5;
      io_wr = 1'b0; io_rd = 1'b0;
   endtask
   task automatic wr(int a, int d);
      @(posedge clk); #5;
      io_addr = 16'(a); io_wdata = 8'(d); io_wr = 1'b1; io_rd = 1'b0;
      idle();
   endtask
   task automatic rd(int a, int exp, string req);
      @(posedge clk); #5;
      io_addr = 16'(a); io_wr = 1'b0; io_rd = 1'b1;
      @(negedge clk);
      chk(req, int'(io_rdata), exp);
      idle();
   endtask
   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #5 rst_n = 1'b1;
   endtask

   initial begin
      #(20 * 100000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      cur_req = "R1";
      @(negedge clk);
      chk("R1 open", int'(cfg_open), 0);
      chk("R1 base", int'(par_base), 'h378);
      rd('h3F1, 'hFF, "R1");
      // R5 locked accesses
      cur_req = "R5";
      rd('h3F0, 'hFF, "R5");
      wr('h3F1, 'h12);
      chk("R5 base", int'(par_base), 'h378);
      // R2 / R3 key counting
      cur_req = "R2";
      wr('h3F0, 'h55);
      chk("R2 one key", int'(cfg_open), 0);
      cur_req = "R3";
      wr('h3F0, 'h11);
      wr('h3F0, 'h55);
      chk("R3 restart", int'(cfg_open), 0);
      cur_req = "R2";
      wr('h3F0, 'h55);
      chk("R2 open", int'(cfg_open), 1);
      // R6 device id
      cur_req = "R6";
      rd('h3F0, 'h00, "R6 idx");
      wr('h3F0, 'h20);
      rd('h3F0, 'h20, "R6 idx");
      rd('h3F1, 'h02, "R6");
      wr('h3F1, 'h77);
      rd('h3F1, 'h02, "R6 wr ignored");
      // R7 logical device gating
      cur_req = "R7";
      wr('h3F0, 'h60);
      rd('h3F1, 'h00, "R7 gated");
      wr('h3F1, 'h12);
      chk("R7 gated wr", int'(par_base), 'h378);
      wr('h3F0, 'h07); wr('h3F1, 'h03);
      rd('h3F1, 'h03, "R7 ldn");
      wr('h3F0, 'h60);
      rd('h3F1, 'h03, "R7 hi");
      wr('h3F1, 'h02);
      wr('h3F0, 'h61); wr('h3F1, 'h78);
      chk("R7 base", int'(par_base), 'h278);
      // R10 base/4
      cur_req = "R10";
      wr('h3F0, 'h23);
      rd('h3F1, 'h9E, "R10");
      wr('h3F1, 'hDE);
      chk("R10 base", int'(par_base), 'h378);
      // R11 chip id, R12 unmapped
      cur_req = "R11";
      wr('h3F0, 'h09);
      rd('h3F1, 'h0A, "R11");
      wr('h3F1, 'h55);
      rd('h3F1, 'h0A, "R11 wr ignored");
      cur_req = "R12";
      wr('h3F0, 'h5A);
      rd('h3F1, 'h00, "R12");
      wr('h3F1, 'h33);
      rd('h3F1, 'h00, "R12 wr ignored");
      // R4 exit
      cur_req = "R4";
      wr('h3F0, 'hAA);
      chk("R4 locked", int'(cfg_open), 0);
      cur_req = "R5";
      rd('h3F1, 'hFF, "R5 after exit");
      wr('h3F1, 'h01);
      chk("R5 base hold", int'(par_base), 'h378);
      cur_req = "R4";
      wr('h3F0, 'h55); wr('h3F0, 'h55);
      rd('h3F0, 'h5A, "R4 index kept");
      wr('h3F0, 'hAA);

      // R8 / R9 alternative schemes
      for (int s = 0; s < 4; s++) begin
         int kp, ip, dp, kv, nd;
         rst_n = 1'b0;
         strap_alt = 1'b1; strap_sel = 2'(s);
         do_reset();
         kp = (s == 0 || s == 3) ? 'h250 : 'h3F0;
         ip = (kp == 'h250) ? 'h251 : 'h3F0;
         dp = (kp == 'h250) ? 'h252 : 'h3F1;
         kv = (s == 0) ? 'h89 : (s == 1) ? 'h86 : (s == 2) ? 'h87 : 'h88;
         nd = (s == 1 || s == 2) ? 2 : 1;
         cur_req = "R8";
         wr(kp, 'h55);
         chk("R8 primary key rejected", int'(cfg_open), 0);
         if (nd == 2) begin
            wr(kp, kv);
            chk("R8 one of two", int'(cfg_open), 0);
            cur_req = "R3";
            wr(kp, 'h00);
            wr(kp, kv);
            chk("R3 alt restart", int'(cfg_open), 0);
            cur_req = "R8";
         end
         wr(kp, kv);
         chk("R8 open", int'(cfg_open), 1);
         cur_req = "R9";
         wr(ip, 'h20);
         rd(dp, 'h02, "R9 data port");
         if (kp == 'h250) begin
            rd('h3F1, 'hFF, "R9 other pair");
            wr('h3F0, 'h23);
            rd(ip, 'h20, "R9 other pair ignored");
         end else begin
            rd('h252, 'hFF, "R9 other pair");
         end
         cur_req = "R4";
         wr(kp, 'hAA);
         chk("R4 alt exit", int'(cfg_open), 0);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule